// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Controller

This block is the bus-facing controller of a 128-byte serial EEPROM. It watches a two-wire bus (a clock line and an open-drain data line) by oversampling both lines with the system clock. It finds START and STOP conditions, moves bytes in and out most significant bit first, and pulls the data line low through an output enable. A control byte selects read or write. In a write transfer, the byte after the control byte is the word address and the bytes after it are data. Each data byte is handed to an external page buffer. The controller then commits the page at STOP, or drops it if a repeated START arrives first.

Reads come from a synchronous array with one cycle of latency, addressed by the controller's own pointer. The controller supports current-address, random and sequential reads. While the page buffer reports a programming cycle in progress, the controller acknowledges nothing, so a master can poll for completion. A level input gates all writes. When it is low the array behaves as read-only.

Top module: `tw_eeprom_slave`

## Requirements
- R1: A falling data line while the clock line is high (START) restarts control-byte reception from any state. A rising data line while the clock line is high (STOP) returns the block to idle with the data line released.
- R2: A control byte whose upper four bits are 1010 is acknowledged. Bits 3..1 are ignored, and bit 0 selects read (1) or write (0). Any other control byte is not acknowledged, and the block ignores the bus until the next START.
- R3: While `pb_busy` is high, no byte gets an acknowledge, including the control byte.
- R4: In a write transfer, the second byte loads the address pointer. Each later byte produces one `pb_wr_valid` pulse carrying the pointer and the byte. After each data byte, pointer bits 2..0 increment and wrap within the 8-byte group while bits 6..3 hold.
- R5: A read without a preceding address byte returns the byte at the pointer, which is the last accessed address plus one, after either a read or a write.
- R6: A STOP that ends a transfer in which at least one data byte was forwarded produces exactly one single-cycle `pb_commit` pulse.
- R7: A repeated START after forwarded data produces one `pb_drop` pulse and no commit. A write transfer that only sets the address, followed by a repeated START and a read control byte, reads from that address.
- R8: During a read, a master acknowledge after a byte makes the block send the next sequential byte. A master no-acknowledge makes the block release the data line and ignore the bus until a START.
- R9: While `wr_allow` is low, data bytes are still acknowledged but nothing is forwarded and no commit follows.
- R10: The read pointer wraps from address 127 to address 0.
- R11: A START in the middle of a byte aborts the transfer, and the next control byte is handled normally.
- R12: Read data goes out most significant bit first, and the output enable changes only while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line (resolved level) |
| sda_oe | output | 1 | 1 pulls the data line low |
| wr_allow | input | 1 | High permits writes, low write-protects |
| mem_raddr | output | 7 | Array read address (current pointer) |
| mem_rdata | input | 8 | Array read data, one cycle after the address |
| pb_busy | input | 1 | Page buffer programming cycle in progress |
| pb_wr_valid | output | 1 | One-cycle pulse: forward a data byte |
| pb_wr_addr | output | 7 | Address of the forwarded byte |
| pb_wr_data | output | 8 | Forwarded data byte |
| pb_commit | output | 1 | One-cycle pulse: start programming the buffer |
| pb_drop | output | 1 | One-cycle pulse: discard the buffered bytes |

## Verification
The assertions assume a well-formed master. It changes the data line only while the clock line is low, and it never issues a START or STOP while the slave is driving an acknowledge or a data bit. They also assume the clock line holds each level for several system cycles, so the synchronised edges are clean. The bench master drives each quarter bit for five system clocks and moves the data line only in the middle of the low phase. It releases the line for every bit the slave owns, and it places repeated STARTs and aborts only where the slave has let go of the line.

// File: rtl/tw_slave_pkg.sv
package tw_slave_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_TX,
        S_MACK
    } tw_state_e;

    typedef enum logic [1:0] {
        P_CTRL,
        P_WADDR,
        P_WDATA
    } tw_phase_e;

    localparam logic [3:0] CTRL_CODE = 4'b1010;
    localparam int         BYTE_W    = 8;

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] prv
);
    localparam int DEPTH = STAGES + 1;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [DEPTH-1:0] pipe_d, pipe_q;

        always_comb begin
            pipe_d = {pipe_q[DEPTH-2:0], din[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= pipe_d;
        end

        assign lvl[g] = pipe_q[STAGES-1];
        assign prv[g] = pipe_q[STAGES];
    end

endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect (
    input  logic scl_lvl,
    input  logic scl_prv,
    input  logic sda_lvl,
    input  logic sda_prv,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_held_high;

    always_comb begin
        scl_held_high = scl_lvl & scl_prv;
        start_det     = scl_held_high &  sda_prv & ~sda_lvl;
        stop_det      = scl_held_high & ~sda_prv &  sda_lvl;
        scl_rise      = scl_lvl & ~scl_prv;
        scl_fall      = ~scl_lvl & scl_prv;
    end

endmodule

// File: rtl/tw_addr_ptr.sv
module tw_addr_ptr #(
    parameter int ADDR_W = 7,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_rd,
    input  logic              inc_wr,
    output logic [ADDR_W-1:0] ptr
);
    localparam int HI_W = ADDR_W - PAGE_W;

    logic [ADDR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load) begin
            ptr_d = load_val;
        end else if (inc_wr) begin
            ptr_d = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + {{(PAGE_W-1){1'b0}}, 1'b1}};
        end else if (inc_rd) begin
            ptr_d = ptr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R10
    rd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_rd && !load && !inc_wr && ptr_q == {ADDR_W{1'b1}}) |=> (ptr_q == '0));

    // R4
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_wr && !load) |=> (ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])));

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = ptr_q[ADDR_W-1:PAGE_W];

endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
    import tw_slave_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int PAGE_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              wr_allow,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [7:0]        mem_rdata,
    input  logic              pb_busy,
    output logic              pb_wr_valid,
    output logic [ADDR_W-1:0] pb_wr_addr,
    output logic [7:0]        pb_wr_data,
    output logic              pb_commit,
    output logic              pb_drop
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(BYTE_W);

    typedef struct packed {
        tw_state_e         st;
        tw_phase_e         ph;
        logic [CNT_W-1:0]  cnt;
        logic [7:0]        sh;
        logic              rw;
        logic              oe;
        logic              pend;
        logic              mack;
        logic              wr_v;
        logic [ADDR_W-1:0] wr_a;
        logic [7:0]        wr_d;
        logic              commit;
        logic              drop;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [1:0] line_lvl, line_prv;
    logic scl_lvl, sda_lvl;
    logic start_det, stop_det, scl_rise, scl_fall;
    logic ptr_ld, ptr_inc_rd, ptr_inc_wr;
    logic [ADDR_W-1:0] ptr_ld_val, ptr;

    tw_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sda_in, scl_in}),
        .lvl  (line_lvl),
        .prv  (line_prv)
    );

    assign scl_lvl = line_lvl[0];
    assign sda_lvl = line_lvl[1];

    tw_cond_detect u_cond (
        .scl_lvl  (line_lvl[0]),
        .scl_prv  (line_prv[0]),
        .sda_lvl  (line_lvl[1]),
        .sda_prv  (line_prv[1]),
        .start_det(start_det),
        .stop_det (stop_det),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    tw_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ptr_ld),
        .load_val(ptr_ld_val),
        .inc_rd  (ptr_inc_rd),
        .inc_wr  (ptr_inc_wr),
        .ptr     (ptr)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.wr_v   = 1'b0;
        ctl_d.commit = 1'b0;
        ctl_d.drop   = 1'b0;
        ptr_ld       = 1'b0;
        ptr_ld_val   = ctl_q.sh[ADDR_W-1:0];
        ptr_inc_rd   = 1'b0;
        ptr_inc_wr   = 1'b0;

        if (start_det) begin
            ctl_d.st   = S_RX;
            ctl_d.ph   = P_CTRL;
            ctl_d.cnt  = '0;
            ctl_d.oe   = 1'b0;
            ctl_d.drop = ctl_q.pend;
            ctl_d.pend = 1'b0;
        end else if (stop_det) begin
            ctl_d.st     = S_IDLE;
            ctl_d.oe     = 1'b0;
            ctl_d.commit = ctl_q.pend;
            ctl_d.pend   = 1'b0;
        end else begin
            unique case (ctl_q.st)
                S_IDLE: ;
                S_RX: begin
                    if (scl_rise && ctl_q.cnt < FULL_BYTE) begin
                        ctl_d.sh  = {ctl_q.sh[6:0], sda_lvl};
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end else if (scl_fall && ctl_q.cnt == FULL_BYTE) begin
                        if (pb_busy) begin
                            ctl_d.st = S_IDLE;
                        end else begin
                            unique case (ctl_q.ph)
                                P_CTRL: begin
                                    if (ctl_q.sh[7:4] == CTRL_CODE) begin
                                        ctl_d.rw = ctl_q.sh[0];
                                        ctl_d.oe = 1'b1;
                                        ctl_d.st = S_ACK;
                                    end else begin
                                        ctl_d.st = S_IDLE;
                                    end
                                end
                                P_WADDR: begin
                                    ptr_ld   = 1'b1;
                                    ctl_d.oe = 1'b1;
                                    ctl_d.st = S_ACK;
                                end
                                default: begin
                                    ctl_d.oe = 1'b1;
                                    ctl_d.st = S_ACK;
                                    if (wr_allow) begin
                                        ctl_d.wr_v = 1'b1;
                                        ctl_d.wr_a = ptr;
                                        ctl_d.wr_d = ctl_q.sh;
                                        ctl_d.pend = 1'b1;
                                        ptr_inc_wr = 1'b1;
                                    end
                                end
                            endcase
                        end
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        ctl_d.cnt = '0;
                        if (ctl_q.ph == P_CTRL && ctl_q.rw) begin
                            ctl_d.st   = S_TX;
                            ctl_d.sh   = mem_rdata;
                            ctl_d.oe   = ~mem_rdata[7];
                            ptr_inc_rd = 1'b1;
                        end else begin
                            ctl_d.st = S_RX;
                            ctl_d.oe = 1'b0;
                            ctl_d.ph = (ctl_q.ph == P_CTRL) ? P_WADDR : P_WDATA;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (ctl_q.cnt == LAST_BIT) begin
                            ctl_d.oe = 1'b0;
                            ctl_d.st = S_MACK;
                        end else begin
                            ctl_d.sh  = {ctl_q.sh[6:0], 1'b0};
                            ctl_d.oe  = ~ctl_q.sh[6];
                            ctl_d.cnt = ctl_q.cnt + 1'b1;
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) begin
                        ctl_d.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        ctl_d.cnt = '0;
                        if (ctl_q.mack) begin
                            ctl_d.st   = S_TX;
                            ctl_d.sh   = mem_rdata;
                            ctl_d.oe   = ~mem_rdata[7];
                            ptr_inc_rd = 1'b1;
                        end else begin
                            ctl_d.st = S_IDLE;
                        end
                    end
                end
                default: ctl_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= S_IDLE;
            ctl_q.ph <= P_CTRL;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_oe      = ctl_q.oe;
    assign mem_raddr   = ptr;
    assign pb_wr_valid = ctl_q.wr_v;
    assign pb_wr_addr  = ctl_q.wr_a;
    assign pb_wr_data  = ctl_q.wr_d;
    assign pb_commit   = ctl_q.commit;
    assign pb_drop     = ctl_q.drop;

    // R12
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_q.oe) |-> !scl_lvl);

    // R3
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_ACK && $rose(ctl_q.oe)) |-> !$past(pb_busy));

    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !ctl_q.oe);

    // R6
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.commit |=> !ctl_q.commit);

    // R2
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_det && !stop_det && ctl_q.st == S_RX && ctl_q.ph == P_CTRL &&
         scl_fall && ctl_q.cnt == FULL_BYTE && ctl_q.sh[7:4] != CTRL_CODE) |=> !ctl_q.oe);

    // R7
    drop_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.drop |-> !ctl_q.commit);

endmodule

// File: tb/test_tw_eeprom_slave.sv
module test_tw_eeprom_slave;
    localparam int Q    = 5;
    localparam int BUSY = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe, wr_allow, pb_busy;
    logic bus_sda;
    logic [6:0] mem_raddr, pb_wr_addr;
    logic [7:0] mem_rdata, pb_wr_data;
    logic pb_wr_valid, pb_commit, pb_drop;

    assign bus_sda = m_sda & ~sda_oe;

    tw_eeprom_slave i_tw_eeprom_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(bus_sda), .sda_oe(sda_oe),
        .wr_allow(wr_allow), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .pb_busy(pb_busy), .pb_wr_valid(pb_wr_valid), .pb_wr_addr(pb_wr_addr),
        .pb_wr_data(pb_wr_data), .pb_commit(pb_commit), .pb_drop(pb_drop)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    function automatic logic [7:0] init_val(int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    logic [7:0] mem [128];
    logic [7:0] ref_mem [128];
    int busy_cnt = 0;
    logic [7:0] pend_d [8];
    logic [6:0] pend_a [8];
    int pend_n = 0;

    typedef struct { int kind; int a; int d; } ev_t;  // kind 0 write, 1 commit, 2 drop
    ev_t exq[$];

    initial begin
        for (int i = 0; i < 128; i++) begin
            mem[i] = init_val(i);
            ref_mem[i] = init_val(i);
        end
    end

    always @(posedge clk) mem_rdata <= mem[mem_raddr];
    assign pb_busy = (busy_cnt != 0);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: page buffer model and scoreboard pop
    always @(negedge clk) begin
        if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
        if (rst_n && (pb_wr_valid || pb_commit || pb_drop)) begin
            int k;
            k = pb_wr_valid ? 0 : (pb_commit ? 1 : 2);
            checks++;
            if (exq.size() == 0) begin
                errors++;
                $display("FAIL R4/R6/R7/R9 unexpected event actual=%0d expected=none", k);
            end else begin
                ev_t e;
                e = exq.pop_front();
                if (e.kind != k || (k == 0 && (e.a != int'(pb_wr_addr) || e.d != int'(pb_wr_data)))) begin
                    errors++;
                    $display("FAIL R4/R6/R7 event actual=%0d/%0h/%0h expected=%0d/%0h/%0h",
                             k, pb_wr_addr, pb_wr_data, e.kind, e.a, e.d);
                end
            end
            if (pb_wr_valid) begin
                pend_a[pend_n % 8] = pb_wr_addr;
                pend_d[pend_n % 8] = pb_wr_data;
                pend_n++;
            end
            if (pb_commit) begin
                for (int i = 0; i < pend_n && i < 8; i++) mem[pend_a[i]] = pend_d[i];
                pend_n = 0;
                busy_cnt <= BUSY;
            end
            if (pb_drop) pend_n = 0;
        end
    end

    task automatic qw; repeat (Q) @(negedge clk); endtask

    task automatic m_start;
        m_sda = 1'b1; qw; m_scl = 1'b1; qw; m_sda = 1'b0; qw; m_scl = 1'b0; qw;
    endtask

    task automatic m_stop;
        m_sda = 1'b0; qw; m_scl = 1'b1; qw; m_sda = 1'b1; qw;
    endtask

    task automatic m_bit(input logic b, output logic r);
        m_sda = b; qw; m_scl = 1'b1; qw; r = bus_sda; qw; m_scl = 1'b0; qw;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(b[i], r);
        m_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            b[i] = r;
        end
        m_bit(~mack, r);
    endtask

    task automatic push_ev(input int k, input int a, input int d);
        ev_t e;
        e.kind = k; e.a = a; e.d = d;
        exq.push_back(e);
    endtask

    task automatic wait_ready;
        for (int i = 0; i < 2000 && pb_busy; i++) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic set_addr(input logic [6:0] a);
        logic ack;
        m_start;
        send_byte(8'hA0, ack); chk(ack, "R2 write control ack", ack, 1);
        send_byte({1'b0, a}, ack); chk(ack, "R4 word address ack", ack, 1);
    endtask

    task automatic rd_ctrl;
        logic ack;
        m_start;
        send_byte(8'hA1, ack); chk(ack, "R2 read control ack", ack, 1);
    endtask

    initial begin
        logic ack;
        logic [7:0] b;
        wr_allow = 1'b1;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(sda_oe == 0 && pb_wr_valid == 0 && pb_commit == 0, "R1 reset outputs idle", sda_oe, 0);

        // R2 wrong code then ignored without START
        m_start;
        send_byte(8'h50, ack); chk(!ack, "R2 wrong code nack", ack, 0);
        send_byte(8'hA0, ack); chk(!ack, "R2 ignored until START", ack, 0);
        m_stop;

        // R4 R6 byte write, don't-care bits set
        m_start;
        send_byte(8'hA6, ack); chk(ack, "R2 ignored bits ack", ack, 1);
        send_byte(8'h10, ack); chk(ack, "R4 address ack", ack, 1);
        push_ev(0, 'h10, 'h5A); push_ev(1, 0, 0);
        send_byte(8'h5A, ack); chk(ack, "R4 data ack", ack, 1);
        m_stop;
        ref_mem['h10] = 8'h5A;
        repeat (3) @(negedge clk);
        chk(sda_oe == 0, "R1 released after STOP", sda_oe, 0);

        // R3 polling while busy
        m_start;
        send_byte(8'hA0, ack); chk(!ack, "R3 nack while busy", ack, 0);
        m_stop;
        wait_ready;
        m_start;
        send_byte(8'hA0, ack); chk(ack, "R3 ack after busy", ack, 1);
        m_stop;

        // R7 random read
        set_addr(7'h10);
        rd_ctrl;
        recv_byte(1'b0, b); chk(b == ref_mem['h10], "R7 random read", b, ref_mem['h10]);
        repeat (4) @(negedge clk);
        chk(sda_oe == 0, "R8 release after nack", sda_oe, 0);
        m_stop;

        // R5 current address after read
        rd_ctrl;
        recv_byte(1'b0, b); chk(b == ref_mem['h11], "R5 current read after read", b, ref_mem['h11]);
        m_stop;

        // R8 R10 sequential with wrap, R12 MSB first
        set_addr(7'h7E);
        rd_ctrl;
        recv_byte(1'b1, b); chk(b == ref_mem['h7E], "R12 seq byte 7E", b, ref_mem['h7E]);
        recv_byte(1'b1, b); chk(b == ref_mem['h7F], "R8 seq byte 7F", b, ref_mem['h7F]);
        recv_byte(1'b0, b); chk(b == ref_mem[0], "R10 wrap to 0", b, ref_mem[0]);
        m_stop;

        // R9 write protect
        wr_allow = 1'b0;
        set_addr(7'h20);
        send_byte(8'h99, ack); chk(ack, "R9 protected data ack", ack, 1);
        m_stop;
        repeat (20) @(negedge clk);
        chk(pb_busy == 0, "R9 no commit when protected", pb_busy, 0);
        wr_allow = 1'b1;
        set_addr(7'h20);
        rd_ctrl;
        recv_byte(1'b0, b); chk(b == ref_mem['h20], "R9 array unchanged", b, ref_mem['h20]);
        m_stop;

        // R4 page wrap of low bits
        set_addr(7'h0E);
        push_ev(0, 'h0E, 'h11); push_ev(0, 'h0F, 'h22); push_ev(0, 'h08, 'h33); push_ev(1, 0, 0);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack); chk(ack, "R4 third data ack", ack, 1);
        m_stop;
        ref_mem['h0E] = 8'h11; ref_mem['h0F] = 8'h22; ref_mem['h08] = 8'h33;
        wait_ready;
        rd_ctrl;
        recv_byte(1'b0, b); chk(b == ref_mem['h09], "R5 current read after write", b, ref_mem['h09]);
        m_stop;
        set_addr(7'h08);
        rd_ctrl;
        recv_byte(1'b0, b); chk(b == 8'h33, "R4 page wrapped byte", b, 8'h33);
        m_stop;

        // R7 repeated START drops written data
        set_addr(7'h30);
        push_ev(0, 'h30, 'h77); push_ev(2, 0, 0);
        send_byte(8'h77, ack);
        rd_ctrl;
        recv_byte(1'b0, b); chk(b == ref_mem['h31], "R7 read after drop", b, ref_mem['h31]);
        m_stop;

        // R11 mid-byte START abort
        m_start;
        for (int i = 0; i < 4; i++) m_bit(i[0] ? 1'b0 : 1'b1, ack);
        rd_ctrl;
        recv_byte(1'b0, b); chk(b == ref_mem['h32], "R11 read after abort", b, ref_mem['h32]);
        m_stop;

        set_addr(7'h30);
        rd_ctrl;
        recv_byte(1'b0, b); chk(b == ref_mem['h30], "R7 dropped byte not written", b, ref_mem['h30]);
        m_stop;

        repeat (20) @(negedge clk);
        chk(exq.size() == 0, "R6 all expected events seen", exq.size(), 0);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule